// File: doc/BRIEF.md
# Raster-Synchronised Display List Coprocessor

This block walks a list of two-word commands held in memory and acts on each one in step with the raster beam. It only touches memory in bus slots it is granted. In each such slot it reads one 16-bit word, and its word address then steps forward. A command can do one of three things. It can write a value to a display register. It can hold execution until the beam reaches a position. It can skip the following command once the beam has passed a position.

The beam position is a 16-bit value built from the low eight bits of the line number (upper byte) and the horizontal slot (lower byte). The hold and skip commands compare this position against a target under a mask supplied by the command. They can also require the blitter to be idle. A hold command whose target has already been reached does not stall; the next fetch follows at once. While the unit is holding, it evaluates the condition in each granted slot and does not claim that slot. Other bus users can then take it.

Software points the unit at a list by driving a start address and pulsing a restart strobe.

Top module: `raster_list_coproc`

## Requirements
- R1: Each command is read as two 16-bit words in consecutive granted slots, and `mem_addr` advances by one after each word. With no grant, `mem_addr` holds its value.
- R2: A command whose first word has bit 0 = 0 is a register write. One cycle after its second word is read, `reg_wr` pulses for one cycle, with `reg_addr` = first word bits 8:1 and `reg_data` = the second word.
- R3: For hold and skip commands, the mask is 0x8000 OR (second word AND 0x7FFE). The beam position is {beam_line, beam_hslot}. The beam condition holds when (position AND mask) ≥ (first word AND mask), compared unsigned. Bit 15 is therefore always compared and bit 0 never is.
- R4: While `blit_busy` is 1, the condition fails unless bit 15 of the second word is 1.
- R5: A hold command (first word bit 0 = 1, second word bit 0 = 0) whose condition already holds when its second word is read lets the next command's fetch proceed in the very next granted slot.
- R6: A hold command whose condition fails enters a holding state. In each granted slot it re-evaluates the condition, keeps `bus_claim` at 0 and leaves `mem_addr` unchanged. Once the condition holds, fetching resumes in the following granted slot.
- R7: A skip command (both bit 0s = 1) whose condition holds advances `mem_addr` by three after its second word, passing over the next command. Otherwise execution continues in order.
- R8: A `restart` pulse, which takes priority over a grant, loads `mem_addr` with `list_start` on the next cycle and restarts decoding with a first-word fetch.
- R9: After reset, `mem_addr` is 0, `reg_wr` is 0 and the unit is ready to fetch a first word.
- R10: `bus_claim` is 1 exactly in the granted slots that the unit uses for a fetch, and it is never 1 without `slot_grant`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_grant | input | 1 | This cycle's bus slot is offered to the unit |
| bus_claim | output | 1 | The unit uses the offered slot for a fetch |
| mem_addr | output | AW | Word address of the next list word |
| mem_rdata | input | 16 | Word at `mem_addr`, valid in the same cycle |
| beam_line | input | 8 | Low eight bits of the current raster line |
| beam_hslot | input | 8 | Current horizontal slot |
| blit_busy | input | 1 | Blitter is still running |
| list_start | input | AW | List start address loaded by restart |
| restart | input | 1 | Reload the list address and start over |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 8 | Register offset of the write |
| reg_data | output | 16 | Data of the write |

## Verification
The assertions assume that memory returns the word for the presented `mem_addr` in the same cycle. They also assume that `restart` and `list_start` are driven only from clocked logic, so that both are steady around each edge. The bench keeps to this by modelling memory as a combinational array indexed by `mem_addr`. All inputs, beam position and blitter status included, change only on the falling clock edge. Hold conditions are released by moving the beam or clearing `blit_busy` between edges, never within a cycle.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  localparam int WORD_W = 16;
  localparam int REGOFS_W = 8;
  localparam logic [WORD_W-1:0] CMP_FIXED = 16'h8000;
  localparam logic [WORD_W-1:0] CMP_SELECT = 16'h7FFE;

  typedef enum logic [1:0] {
    ST_FIRST  = 2'd0,
    ST_SECOND = 2'd1,
    ST_HOLD   = 2'd2
  } rlc_state_e;
endpackage

// File: rtl/rlc_cond.sv
module rlc_cond
  import rlc_pkg::*;
(
  input  logic [WORD_W-1:0] beam_pos,
  input  logic [WORD_W-1:0] target_w,
  input  logic [WORD_W-1:0] ctrl_w,
  input  logic              blit_busy,
  output logic              hit
);
  logic [WORD_W-1:0] mask;
  logic              beam_ok;
  logic              blit_ok;

  always_comb begin
    mask    = CMP_FIXED | (ctrl_w & CMP_SELECT);
    beam_ok = (beam_pos & mask) >= (target_w & mask);
    blit_ok = !blit_busy || ctrl_w[WORD_W-1];
    hit     = beam_ok && blit_ok;
  end
endmodule

// File: rtl/rlc_seq.sv
module rlc_seq
  import rlc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                slot_grant,
  input  logic                restart,
  input  logic [AW-1:0]       list_start,
  input  logic [WORD_W-1:0]   mem_rdata,
  input  logic                cmp_hit,
  output logic [WORD_W-1:0]   cmp_target,
  output logic [WORD_W-1:0]   cmp_ctrl,
  output logic                bus_claim,
  output logic [AW-1:0]       mem_addr,
  output logic                reg_wr,
  output logic [REGOFS_W-1:0] reg_addr,
  output logic [WORD_W-1:0]   reg_data
);
  localparam logic [AW-1:0] STEP_ONE  = AW'(1);
  localparam logic [AW-1:0] STEP_SKIP = AW'(3);

  rlc_state_e        state_q;
  logic [AW-1:0]     pc_q;
  logic [WORD_W-1:0] w0_q;
  logic [WORD_W-1:0] w1_q;

  assign mem_addr   = pc_q;
  assign cmp_target = w0_q;
  assign cmp_ctrl   = (state_q == ST_HOLD) ? w1_q : mem_rdata;
  assign bus_claim  = slot_grant && !restart && (state_q != ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_FIRST;
      pc_q     <= '0;
      w0_q     <= '0;
      w1_q     <= '0;
      reg_wr   <= 1'b0;
      reg_addr <= '0;
      reg_data <= '0;
    end else begin
      reg_wr <= 1'b0;
      if (restart) begin
        pc_q    <= list_start;
        state_q <= ST_FIRST;
      end else if (slot_grant) begin
        case (state_q)
          ST_FIRST: begin
            w0_q    <= mem_rdata;
            pc_q    <= pc_q + STEP_ONE;
            state_q <= ST_SECOND;
          end
          ST_SECOND: begin
            w1_q    <= mem_rdata;
            pc_q    <= pc_q + STEP_ONE;
            state_q <= ST_FIRST;
            if (!w0_q[0]) begin
              reg_wr   <= 1'b1;
              reg_addr <= w0_q[REGOFS_W:1];
              reg_data <= mem_rdata;
            end else if (!mem_rdata[0]) begin
              if (!cmp_hit) state_q <= ST_HOLD;
            end else if (cmp_hit) begin
              pc_q <= pc_q + STEP_SKIP;
            end
          end
          ST_HOLD: begin
            if (cmp_hit) state_q <= ST_FIRST;
          end
          default: state_q <= ST_FIRST;
        endcase
      end
    end
  end
endmodule

// File: rtl/raster_list_coproc.sv
module raster_list_coproc
  import rlc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                slot_grant,
  output logic                bus_claim,
  output logic [AW-1:0]       mem_addr,
  input  logic [WORD_W-1:0]   mem_rdata,
  input  logic [7:0]          beam_line,
  input  logic [7:0]          beam_hslot,
  input  logic                blit_busy,
  input  logic [AW-1:0]       list_start,
  input  logic                restart,
  output logic                reg_wr,
  output logic [REGOFS_W-1:0] reg_addr,
  output logic [WORD_W-1:0]   reg_data
);
  logic [WORD_W-1:0] beam_pos;
  logic [WORD_W-1:0] cmp_target;
  logic [WORD_W-1:0] cmp_ctrl;
  logic              cmp_hit;

  assign beam_pos = {beam_line, beam_hslot};

  rlc_cond u_cond (
    .beam_pos  (beam_pos),
    .target_w  (cmp_target),
    .ctrl_w    (cmp_ctrl),
    .blit_busy (blit_busy),
    .hit       (cmp_hit)
  );

  rlc_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .slot_grant (slot_grant),
    .restart    (restart),
    .list_start (list_start),
    .mem_rdata  (mem_rdata),
    .cmp_hit    (cmp_hit),
    .cmp_target (cmp_target),
    .cmp_ctrl   (cmp_ctrl),
    .bus_claim  (bus_claim),
    .mem_addr   (mem_addr),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_data   (reg_data)
  );
endmodule

// File: rtl/rlc_checker.sv
module rlc_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          slot_grant,
  input logic          bus_claim,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] list_start,
  input logic          restart,
  input logic          reg_wr
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_claim_needs_grant_R10: assert property (@(posedge clk) disable iff (rst)
    bus_claim |-> slot_grant);

  assert_write_after_slot_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && reg_wr) |-> $past(slot_grant) && !$past(restart));

  assert_addr_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (armed && !slot_grant && !restart) |=> $stable(mem_addr));

  assert_addr_hold_waiting_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && slot_grant && !bus_claim && !restart) |=> $stable(mem_addr));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && bus_claim) |=>
      (mem_addr == $past(mem_addr) + AW'(1)) || (mem_addr == $past(mem_addr) + AW'(3)));

  assert_restart_load_R8: assert property (@(posedge clk) disable iff (rst)
    (armed && restart) |=> mem_addr == $past(list_start));
endmodule

bind raster_list_coproc rlc_checker #(.AW(AW)) u_rlc_checker (
  .clk        (clk),
  .rst        (rst),
  .slot_grant (slot_grant),
  .bus_claim  (bus_claim),
  .mem_addr   (mem_addr),
  .list_start (list_start),
  .restart    (restart),
  .reg_wr     (reg_wr)
);

// File: tb/tb_raster_list_coproc.sv
module tb_raster_list_coproc;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          slot_grant = 1'b0;
  logic          bus_claim;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_rdata;
  logic [7:0]    beam_line = 8'h00;
  logic [7:0]    beam_hslot = 8'h00;
  logic          blit_busy = 1'b0;
  logic [AW-1:0] list_start = '0;
  logic          restart = 1'b0;
  logic          reg_wr;
  logic [7:0]    reg_addr;
  logic [15:0]   reg_data;

  logic [15:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];

  always #4 clk = ~clk;

  raster_list_coproc #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .slot_grant(slot_grant), .bus_claim(bus_claim),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .beam_line(beam_line),
    .beam_hslot(beam_hslot), .blit_busy(blit_busy), .list_start(list_start),
    .restart(restart), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data)
  );

  int checks = 0;
  int errors = 0;
  int wr_n = 0;
  logic [7:0]  log_a [0:63];
  logic [15:0] log_d [0:63];

  always @(posedge clk) begin
    if (reg_wr) begin
      log_a[wr_n % 64] = reg_addr;
      log_d[wr_n % 64] = reg_data;
      wr_n = wr_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic grant_run(input int n);
    slot_grant = 1'b1;
    tick(n);
    slot_grant = 1'b0;
  endtask

  task automatic do_restart(input logic [AW-1:0] a);
    list_start = a;
    restart = 1'b1;
    slot_grant = 1'b1;
    tick(1);
    restart = 1'b0;
    slot_grant = 1'b0;
    check(mem_addr == a, "R8", mem_addr, a);
  endtask

  task automatic expect_write(input int idx, input logic [7:0] a, input logic [15:0] d, input string req);
    check(log_a[idx % 64] == a, req, log_a[idx % 64], a);
    check(log_d[idx % 64] == d, req, log_d[idx % 64], d);
  endtask

  task automatic t_reset();
    check(mem_addr == 0, "R9", mem_addr, 0);
    check(reg_wr == 1'b0, "R9", reg_wr, 0);
    tick(5);
    check(mem_addr == 0, "R1", mem_addr, 0);
    slot_grant = 1'b1; #1;
    check(bus_claim == 1'b1, "R10", bus_claim, 1);
    slot_grant = 1'b0; #1;
    check(bus_claim == 1'b0, "R10", bus_claim, 0);
  endtask

  task automatic t_moves();
    int base;
    mem[8'h10] = 16'h0024; mem[8'h11] = 16'hABCD;
    mem[8'h12] = 16'h000A; mem[8'h13] = 16'h1234;
    do_restart(16'h0010);
    base = wr_n;
    grant_run(4);
    tick(2);
    check(wr_n - base == 2, "R2", wr_n - base, 2);
    expect_write(base, 8'h12, 16'hABCD, "R2");
    expect_write(base + 1, 8'h05, 16'h1234, "R2");
    check(mem_addr == 16'h0014, "R1", mem_addr, 16'h14);
    do_restart(16'h0010);
    base = wr_n;
    for (int i = 0; i < 8; i++) begin
      slot_grant = (i % 2 == 0);
      tick(1);
    end
    slot_grant = 1'b0;
    tick(2);
    check(wr_n - base == 2, "R1", wr_n - base, 2);
    check(mem_addr == 16'h0014, "R1", mem_addr, 16'h14);
  endtask

  task automatic t_wait_passed();
    int base;
    mem[8'h20] = 16'h3001; mem[8'h21] = 16'hFFFE;
    mem[8'h22] = 16'h000E; mem[8'h23] = 16'h5555;
    beam_line = 8'h40; beam_hslot = 8'h10;
    do_restart(16'h0020);
    base = wr_n;
    grant_run(2);
    slot_grant = 1'b1; #1;
    check(bus_claim == 1'b1, "R5", bus_claim, 1);
    slot_grant = 1'b0;
    check(mem_addr == 16'h0022, "R5", mem_addr, 16'h22);
    grant_run(2);
    tick(2);
    check(wr_n - base == 1, "R5", wr_n - base, 1);
    expect_write(base, 8'h07, 16'h5555, "R5");
  endtask

  task automatic t_wait_blocked();
    int base;
    beam_line = 8'h20; beam_hslot = 8'h00;
    do_restart(16'h0020);
    base = wr_n;
    grant_run(2);
    slot_grant = 1'b1; #1;
    check(bus_claim == 1'b0, "R6", bus_claim, 0);
    tick(3);
    slot_grant = 1'b0;
    check(mem_addr == 16'h0022, "R6", mem_addr, 16'h22);
    check(wr_n == base, "R6", wr_n - base, 0);
    beam_line = 8'h30;
    grant_run(1);
    slot_grant = 1'b1; #1;
    check(bus_claim == 1'b1, "R6", bus_claim, 1);
    tick(2);
    slot_grant = 1'b0;
    tick(2);
    check(wr_n - base == 1, "R6", wr_n - base, 1);
  endtask

  task automatic t_mask();
    int base;
    mem[8'h30] = 16'h0021; mem[8'h31] = 16'h00FE;
    mem[8'h32] = 16'h0002; mem[8'h33] = 16'h7777;
    beam_line = 8'h7F; beam_hslot = 8'h1F;
    do_restart(16'h0030);
    base = wr_n;
    grant_run(4);
    check(mem_addr == 16'h0032, "R3", mem_addr, 16'h32);
    check(wr_n == base, "R3", wr_n - base, 0);
    beam_line = 8'h80;
    grant_run(3);
    tick(2);
    check(wr_n - base == 1, "R3", wr_n - base, 1);
    expect_write(base, 8'h01, 16'h7777, "R3");
    beam_line = 8'h00; beam_hslot = 8'h21;
    do_restart(16'h0030);
    base = wr_n;
    grant_run(4);
    tick(2);
    check(wr_n - base == 1, "R3", wr_n - base, 1);
  endtask

  task automatic t_blitter();
    int base;
    mem[8'h40] = 16'h0001; mem[8'h41] = 16'h7FFE;
    mem[8'h42] = 16'h0004; mem[8'h43] = 16'h4242;
    mem[8'h48] = 16'h0001; mem[8'h49] = 16'hFFFE;
    mem[8'h4A] = 16'h0006; mem[8'h4B] = 16'h4343;
    beam_line = 8'h10; beam_hslot = 8'h00;
    blit_busy = 1'b1;
    do_restart(16'h0040);
    base = wr_n;
    grant_run(5);
    check(mem_addr == 16'h0042, "R4", mem_addr, 16'h42);
    blit_busy = 1'b0;
    grant_run(3);
    tick(2);
    check(wr_n - base == 1, "R4", wr_n - base, 1);
    blit_busy = 1'b1;
    do_restart(16'h0048);
    base = wr_n;
    grant_run(4);
    tick(2);
    check(wr_n - base == 1, "R4", wr_n - base, 1);
    expect_write(base, 8'h03, 16'h4343, "R4");
    blit_busy = 1'b0;
  endtask

  task automatic t_skip();
    int base;
    mem[8'h50] = 16'h0001; mem[8'h51] = 16'hFFFF;
    mem[8'h52] = 16'h0002; mem[8'h53] = 16'h1111;
    mem[8'h54] = 16'h0004; mem[8'h55] = 16'h2222;
    mem[8'h58] = 16'hFF01; mem[8'h59] = 16'hFFFF;
    mem[8'h5A] = 16'h0002; mem[8'h5B] = 16'h1111;
    beam_line = 8'h20; beam_hslot = 8'h00;
    do_restart(16'h0050);
    base = wr_n;
    grant_run(2);
    check(mem_addr == 16'h0054, "R7", mem_addr, 16'h54);
    grant_run(2);
    tick(2);
    check(wr_n - base == 1, "R7", wr_n - base, 1);
    expect_write(base, 8'h02, 16'h2222, "R7");
    do_restart(16'h0058);
    base = wr_n;
    grant_run(4);
    tick(2);
    check(wr_n - base == 1, "R7", wr_n - base, 1);
    expect_write(base, 8'h01, 16'h1111, "R7");
  endtask

  task automatic t_restart_hold();
    int base;
    beam_line = 8'h00;
    do_restart(16'h0020);
    grant_run(3);
    check(mem_addr == 16'h0022, "R8", mem_addr, 16'h22);
    do_restart(16'h0010);
    base = wr_n;
    grant_run(2);
    tick(2);
    check(wr_n - base == 1, "R8", wr_n - base, 1);
    expect_write(base, 8'h12, 16'hABCD, "R8");
  endtask

  bit done = 1'b0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_moves();
    t_wait_passed();
    t_wait_blocked();
    t_mask();
    t_blitter();
    t_skip();
    t_restart_hold();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule